// File: doc/BRIEF.md
# Status-Coded I2C Master Transmitter

This block drives an I2C bus as a write-only master. Software steers it through a byte-wide control register that has separate set and clear write ports. After every bus event (START sent, address byte done, data byte done, arbitration lost) the block raises an interrupt flag and publishes a fixed 8-bit status code. While that flag stays set, it keeps SCL low so the bus waits for software. Software loads the next byte into a data register and clears the flag to let the transfer continue. It asks for STOP by setting the stop bit before it clears the flag.

The bus pins are open-drain. Each line has an input and an active-high pull-low enable. A programmable prescaler sets the bit rate: one SCL half-period is (prescale + 1) clock cycles. In the high half the block also waits for the SCL line to actually read high. The block watches both lines at all times. It treats the bus as busy from any START it sees until any STOP it sees, and never begins its own START while the bus is busy.

Top module: `i2c_stx_top`

## Requirements
- R1: After reset, the status code is 0xF8, the control register reads 0, the interrupt flag is low and neither line is pulled low.
- R2: Register writes use these offsets: 0 sets control bits, 1 clears control bits (a 1 clears the matching bit), 2 loads the data register, 3 loads the prescaler. The control bits are enable (bit 6), start request (bit 5), stop request (bit 4), interrupt flag (bit 3) and acknowledge enable (bit 2). Bits 7, 1 and 0 always read 0.
- R3: A START request waits while the bus is busy, meaning after a START seen on the lines and before the next STOP. START is issued only after the bus goes free.
- R4: After the block drives START (SDA falling while SCL is high), it sets the interrupt flag with status 0x08. SCL stays pulled low for as long as the flag stays set.
- R5: When the flag is cleared with no stop request, the data register is sent as 8 bits, most significant bit first. A ninth clock then samples the acknowledge. The first byte after START is the 7-bit address followed by write bit 0.
- R6: After the first byte, the flag is set with status 0x18 if the byte was acknowledged and 0x20 if it was not.
- R7: After each later byte, the flag is set with status 0x28 if the byte was acknowledged and 0x30 if it was not.
- R8: The block detects arbitration loss when it releases SDA during an SCL-high phase and SDA reads low. It then releases both lines, sets the flag with status 0x38 and returns to idle.
- R9: When the stop request is set and the flag is cleared, the block drives STOP (SDA rising while SCL is high). It then clears the stop request by itself, shows status 0x F8 and leaves the flag low.
- R10: Clearing the enable bit puts the block back in idle at once: both lines are released and the status becomes 0xF8.
- R11: No START is issued while the enable bit is 0 or while the interrupt flag is set, even if a start is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register offset (0 set, 1 clear, 2 data, 3 prescale) |
| wrData | input | 8 | Register write data |
| ctrlOut | output | 8 | Current control register |
| statusCode | output | 8 | Current status code |
| irq | output | 1 | Interrupt flag (control bit 3) |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | Pull SDA low when 1 |
| sclIn | input | 1 | SCL line level |
| sclOe | output | 1 | Pull SCL low when 1 |

## Verification
A register write shows up on ctrlOut one cycle after the write edge. The bench therefore samples on the falling edge right after each write. How long a bus result takes depends on the prescaler and on SCL reaching the high level, so the bench waits for the interrupt flag within a bounded number of cycles and reads the status code in the same half-cycle in which the flag is seen. When the block returns to idle, SCL is released one cycle after the state change and SDA two cycles after it, because SDA has an extra stage that keeps it from changing while SCL is high. Release checks are therefore sampled at least three cycles after the status or stop bit changes. An open-drain slave model in the bench records each byte, drives acknowledges, and can pull SDA low to imitate a competing master.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;

  localparam logic [1:0] REG_SET   = 2'd0;
  localparam logic [1:0] REG_CLR   = 2'd1;
  localparam logic [1:0] REG_DATA  = 2'd2;
  localparam logic [1:0] REG_PRESC = 2'd3;

  localparam int CB_EN  = 6;
  localparam int CB_STA = 5;
  localparam int CB_STO = 4;
  localparam int CB_SI  = 3;
  localparam logic [7:0] CTRL_MASK = 8'h7C;

  localparam logic [7:0] ST_START     = 8'h08;
  localparam logic [7:0] ST_ADDR_ACK  = 8'h18;
  localparam logic [7:0] ST_ADDR_NACK = 8'h20;
  localparam logic [7:0] ST_DATA_ACK  = 8'h28;
  localparam logic [7:0] ST_DATA_NACK = 8'h30;
  localparam logic [7:0] ST_LOST      = 8'h38;
  localparam logic [7:0] ST_IDLE      = 8'hF8;

  typedef enum logic [3:0] {
    S_IDLE, S_START_H, S_START_L, S_HOLD, S_BIT_LO, S_BIT_HI,
    S_ACK_LO, S_ACK_HI, S_ACK_END, S_STOP_A, S_STOP_B, S_STOP_C
  } stxState_e;

  typedef struct packed {
    logic sdaLow;
    logic sclLow;
    logic loadShift;
    logic shift;
    logic timerClr;
  } stxStrobe_t;

endpackage

// File: rtl/i2c_stx_datapath.sv
module i2c_stx_datapath
  import i2c_stx_pkg::*;
#(
  parameter int PRESC_W   = 8,
  parameter int PRESC_RST = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  stxStrobe_t strobe,
  input  logic       sdaIn,
  input  logic       sclIn,
  output logic       tick,
  output logic       txBit,
  output logic       lastBit,
  output logic       sdaQ,
  output logic       sclQ,
  output logic       busBusy,
  output logic       sdaOe,
  output logic       sclOe
);

  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] cnt;
  logic [7:0]         dataReg;
  logic [7:0]         txShift;
  logic [2:0]         bitCnt;
  logic               sdaPrev, sclPrev, sdaStage;
  logic               startSeen, stopSeen;

  assign tick      = (cnt == presc);
  assign txBit     = txShift[7];
  assign lastBit   = (bitCnt == 3'd7);
  // bus conditions seen on the sampled lines, whoever drove them
  assign startSeen = sclQ && sclPrev && sdaPrev && !sdaQ;
  assign stopSeen  = sclQ && sclPrev && !sdaPrev && sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc    <= PRESC_W'(PRESC_RST);
      cnt      <= '0;
      dataReg  <= '0;
      txShift  <= '0;
      bitCnt   <= '0;
      sdaQ     <= 1'b1;
      sclQ     <= 1'b1;
      sdaPrev  <= 1'b1;
      sclPrev  <= 1'b1;
      busBusy  <= 1'b0;
      sclOe    <= 1'b0;
      sdaStage <= 1'b0;
      sdaOe    <= 1'b0;
    end else begin
      if (wrEn && wrAddr == REG_DATA)  dataReg <= wrData;
      if (wrEn && wrAddr == REG_PRESC) presc   <= PRESC_W'(wrData);
      if (strobe.timerClr || tick) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
      if (strobe.loadShift) begin
        txShift <= dataReg;
        bitCnt  <= '0;
      end else if (strobe.shift) begin
        txShift <= {txShift[6:0], 1'b0};
        bitCnt  <= bitCnt + 1'b1;
      end
      sdaQ    <= sdaIn;
      sclQ    <= sclIn;
      sdaPrev <= sdaQ;
      sclPrev <= sclQ;
      if (startSeen)     busBusy <= 1'b1;
      else if (stopSeen) busBusy <= 1'b0;
      // SDA lags SCL by one stage so data never moves while SCL is high
      sclOe    <= strobe.sclLow;
      sdaStage <= strobe.sdaLow;
      sdaOe    <= sdaStage;
    end
  end

endmodule

// File: rtl/i2c_stx_control.sv
module i2c_stx_control
  import i2c_stx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       tick,
  input  logic       txBit,
  input  logic       lastBit,
  input  logic       sdaQ,
  input  logic       sclQ,
  input  logic       busBusy,
  output stxStrobe_t strobe,
  output logic [7:0] ctrlOut,
  output logic [7:0] statusCode
);

  stxState_e  state, stateN;
  logic [7:0] ctrl, ctrlN, statusN;
  logic       addrPhase, addrPhaseN, ackSeen, ackSeenN;
  logic       setSi, clrSto, statusLoad;
  logic       en, sta, sto, si;

  assign en = ctrl[CB_EN];
  assign sta = ctrl[CB_STA];
  assign sto = ctrl[CB_STO];
  assign si = ctrl[CB_SI];
  assign ctrlOut = ctrl;

  always_comb begin
    stateN     = state;
    strobe     = '0;
    setSi      = 1'b0;
    clrSto     = 1'b0;
    statusLoad = 1'b0;
    statusN    = statusCode;
    addrPhaseN = addrPhase;
    ackSeenN   = ackSeen;
    unique case (state)
      S_IDLE: if (en && sta && !si && !busBusy) begin
        stateN = S_START_H;
        strobe.timerClr = 1'b1;
      end
      S_START_H: begin
        strobe.sdaLow = 1'b1;
        if (tick) stateN = S_START_L;
      end
      S_START_L: begin
        strobe.sdaLow = 1'b1;
        strobe.sclLow = 1'b1;
        if (tick) begin
          stateN = S_HOLD; setSi = 1'b1; statusLoad = 1'b1;
          statusN = ST_START; addrPhaseN = 1'b1;
        end
      end
      S_HOLD: begin
        strobe.sdaLow = 1'b1;
        strobe.sclLow = 1'b1;
        if (!si) begin
          strobe.timerClr = 1'b1;
          if (sto) stateN = S_STOP_A;
          else begin
            stateN = S_BIT_LO;
            strobe.loadShift = 1'b1;
          end
        end
      end
      S_BIT_LO: begin
        strobe.sclLow = 1'b1;
        strobe.sdaLow = !txBit;
        if (tick) stateN = S_BIT_HI;
      end
      S_BIT_HI: begin
        strobe.sdaLow = !txBit;
        if (sclQ && txBit && !sdaQ) begin
          stateN = S_IDLE; setSi = 1'b1; statusLoad = 1'b1; statusN = ST_LOST;
        end else if (tick && sclQ) begin
          strobe.shift = 1'b1;
          stateN = lastBit ? S_ACK_LO : S_BIT_LO;
        end
      end
      S_ACK_LO: begin
        strobe.sclLow = 1'b1;
        if (tick) stateN = S_ACK_HI;
      end
      S_ACK_HI: if (tick && sclQ) begin
        ackSeenN = !sdaQ;
        stateN = S_ACK_END;
      end
      S_ACK_END: begin
        strobe.sclLow = 1'b1;
        if (tick) begin
          stateN = S_HOLD; setSi = 1'b1; statusLoad = 1'b1; addrPhaseN = 1'b0;
          if (addrPhase) statusN = ackSeen ? ST_ADDR_ACK : ST_ADDR_NACK;
          else           statusN = ackSeen ? ST_DATA_ACK : ST_DATA_NACK;
        end
      end
      S_STOP_A: begin
        strobe.sdaLow = 1'b1;
        strobe.sclLow = 1'b1;
        if (tick) stateN = S_STOP_B;
      end
      S_STOP_B: begin
        strobe.sdaLow = 1'b1;
        if (tick && sclQ) stateN = S_STOP_C;
      end
      S_STOP_C: if (tick) begin
        stateN = S_IDLE; clrSto = 1'b1; statusLoad = 1'b1; statusN = ST_IDLE;
      end
      default: stateN = S_IDLE;
    endcase
    if (!en) begin
      stateN = S_IDLE;
      strobe.sdaLow = 1'b0;
      strobe.sclLow = 1'b0;
      setSi = 1'b0;
      statusLoad = 1'b1;
      statusN = ST_IDLE;
    end
  end

  // software set/clear first, hardware events take priority after
  always_comb begin
    ctrlN = ctrl;
    if (wrEn && wrAddr == REG_SET) ctrlN = ctrlN | (wrData & CTRL_MASK);
    if (wrEn && wrAddr == REG_CLR) ctrlN = ctrlN & ~(wrData & CTRL_MASK);
    if (setSi)  ctrlN[CB_SI]  = 1'b1;
    if (clrSto) ctrlN[CB_STO] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      ctrl       <= '0;
      statusCode <= ST_IDLE;
      addrPhase  <= 1'b0;
      ackSeen    <= 1'b0;
    end else begin
      state     <= stateN;
      ctrl      <= ctrlN;
      addrPhase <= addrPhaseN;
      ackSeen   <= ackSeenN;
      if (statusLoad) statusCode <= statusN;
    end
  end

endmodule

// File: rtl/i2c_stx_top.sv
module i2c_stx_top
  import i2c_stx_pkg::*;
#(
  parameter int PRESC_W   = 8,
  parameter int PRESC_RST = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic [7:0] ctrlOut,
  output logic [7:0] statusCode,
  output logic       irq,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic       sclIn,
  output logic       sclOe
);

  stxStrobe_t strobe;
  logic tick, txBit, lastBit, sdaQ, sclQ, busBusy;

  assign irq = ctrlOut[CB_SI];

  i2c_stx_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tick(tick), .txBit(txBit), .lastBit(lastBit), .sdaQ(sdaQ), .sclQ(sclQ),
    .busBusy(busBusy), .strobe(strobe), .ctrlOut(ctrlOut), .statusCode(statusCode)
  );

  i2c_stx_datapath #(.PRESC_W(PRESC_W), .PRESC_RST(PRESC_RST)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .sdaIn(sdaIn), .sclIn(sclIn), .tick(tick), .txBit(txBit),
    .lastBit(lastBit), .sdaQ(sdaQ), .sclQ(sclQ), .busBusy(busBusy),
    .sdaOe(sdaOe), .sclOe(sclOe)
  );

endmodule

// File: rtl/i2c_stx_checker.sv
module i2c_stx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic       sclOe,
  input logic       irq,
  input logic [7:0] statusCode,
  input logic [7:0] ctrlOut,
  input logic       busBusy
);

  // R3: once the bus has been busy for a while, an idle master does not start pulling SDA
  p_no_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && $past(busBusy) && $past(busBusy, 2) && !sdaOe && !sclOe) |=> !sdaOe);

  // R4: SCL stays low while the flag is set and the block is enabled
  p_scl_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irq && sclOe && ctrlOut[6]) |=> sclOe);

  // R4: a status change comes together with the flag, or is the idle code
  p_status_with_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusCode) |-> (irq || statusCode == 8'hF8));

  // R8: losing arbitration releases both lines
  p_lost_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusCode == 8'h38) |=> ##1 (!sdaOe && !sclOe && irq));

  // R6: only defined codes ever appear
  p_code_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusCode inside {8'h08, 8'h18, 8'h20, 8'h28, 8'h30, 8'h38, 8'hF8});

endmodule

bind i2c_stx_top i2c_stx_checker u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclOe(sclOe), .irq(irq),
  .statusCode(statusCode), .ctrlOut(ctrlOut), .busBusy(busBusy)
);

// File: tb/i2c_stx_top_tb.sv
module i2c_stx_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] ctrlOut, statusCode;
  logic irq, sdaOe, sclOe, sdaIn, sclIn;
  logic extSdaLow = 1'b0, extSclLow = 1'b0, slvSdaLow = 1'b0;

  int checks = 0;
  int fails = 0;
  int startCnt = 0, stopCnt = 0;
  int nackAt = 99;
  bit arbOn = 1'b0;
  logic [7:0] rxLog [0:7];

  always #10 clk = ~clk;

  assign sdaIn = !(sdaOe || extSdaLow || slvSdaLow);
  assign sclIn = !(sclOe || extSclLow);

  i2c_stx_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctrlOut(ctrlOut), .statusCode(statusCode), .irq(irq),
    .sdaIn(sdaIn), .sdaOe(sdaOe), .sclIn(sclIn), .sclOe(sclOe)
  );

  // open-drain slave that records bytes and acknowledges them
  initial begin
    logic prevScl, prevSda;
    int bitIdx, byteIdx;
    logic [7:0] rxByte;
    prevScl = 1'b1; prevSda = 1'b1; bitIdx = 0; byteIdx = 0; rxByte = '0;
    forever begin
      @(negedge clk);
      if (prevScl && sclIn && prevSda && !sdaIn) begin
        bitIdx = 0; byteIdx = 0; startCnt++;
      end else if (prevScl && sclIn && !prevSda && sdaIn) begin
        stopCnt++;
      end
      if (!prevScl && sclIn) begin
        if (bitIdx < 8) rxByte = {rxByte[6:0], sdaIn};
        bitIdx++;
      end
      if (prevScl && !sclIn) begin
        if (bitIdx == 8) begin
          if (byteIdx < 8) rxLog[byteIdx] = rxByte;
          slvSdaLow = (byteIdx != nackAt);
        end else if (bitIdx == 9) begin
          slvSdaLow = 1'b0; bitIdx = 0; byteIdx++;
        end
        if (arbOn && byteIdx == 0 && bitIdx == 2) extSdaLow = 1'b1;
      end
      prevScl = sclIn; prevSda = sdaIn;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIrq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(req, irq, 1);
  endtask

  task automatic waitStop(input string req);
    int n = 0;
    while (ctrlOut[4] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    waitCycles(4);
    chk(req, {ctrlOut[4], irq, sdaOe, sclOe}, 4'b0000);
    chk(req, statusCode, 8'hF8);
  endtask

  task automatic testReset();
    chk("R1 status", statusCode, 8'hF8);
    chk("R1 ctrl", ctrlOut, 8'h00);
    chk("R1 lines", {irq, sdaOe, sclOe}, 3'b000);
  endtask

  task automatic testRegs();
    int s0;
    s0 = startCnt;
    regWrite(2'd0, 8'hBF);
    chk("R2 set mask", ctrlOut, 8'h3C);
    waitCycles(40);
    chk("R11 disabled no start", {sdaOe, sclOe, startCnt - s0}, 34'd0);
    regWrite(2'd1, 8'hFF);
    chk("R2 clear all", ctrlOut, 8'h00);
    regWrite(2'd0, 8'h44);
    regWrite(2'd1, 8'h04);
    chk("R2 clear one bit", ctrlOut, 8'h40);
    regWrite(2'd0, 8'h28);
    waitCycles(60);
    chk("R11 flag blocks start", {sdaOe, startCnt - s0}, 33'd0);
    regWrite(2'd1, 8'h28);
    regWrite(2'd3, 8'h03);
  endtask

  task automatic testWrite();
    int p0;
    nackAt = 2;
    regWrite(2'd2, 8'hB4);
    regWrite(2'd0, 8'h20);
    waitIrq("R4 start flag");
    chk("R4 start status", statusCode, 8'h08);
    waitCycles(50);
    chk("R4 hold while flag", {sclOe, irq}, 2'b11);
    regWrite(2'd1, 8'h28);
    waitIrq("R6 addr flag");
    chk("R6 addr ack", statusCode, 8'h18);
    chk("R5 address byte", rxLog[0], 8'hB4);
    regWrite(2'd2, 8'h3C);
    regWrite(2'd1, 8'h08);
    waitIrq("R7 data flag");
    chk("R7 data ack", statusCode, 8'h28);
    chk("R5 data msb first", rxLog[1], 8'h3C);
    regWrite(2'd2, 8'h81);
    regWrite(2'd1, 8'h08);
    waitIrq("R7 data flag nack");
    chk("R7 data nack", statusCode, 8'h30);
    chk("R5 data byte", rxLog[2], 8'h81);
    p0 = stopCnt;
    regWrite(2'd0, 8'h10);
    regWrite(2'd1, 8'h08);
    waitStop("R9 stop");
    chk("R9 stop seen", stopCnt - p0, 1);
    nackAt = 99;
  endtask

  task automatic testAddrNack();
    nackAt = 0;
    regWrite(2'd2, 8'hB4);
    regWrite(2'd0, 8'h20);
    waitIrq("R4 start flag");
    regWrite(2'd1, 8'h28);
    waitIrq("R6 addr flag");
    chk("R6 addr nack", statusCode, 8'h20);
    regWrite(2'd0, 8'h10);
    regWrite(2'd1, 8'h08);
    waitStop("R9 stop after nack");
    nackAt = 99;
  endtask

  task automatic testArb();
    arbOn = 1'b1;
    regWrite(2'd2, 8'hB4);
    regWrite(2'd0, 8'h20);
    waitIrq("R4 start flag");
    regWrite(2'd1, 8'h28);
    waitIrq("R8 lost flag");
    chk("R8 lost status", statusCode, 8'h38);
    waitCycles(3);
    chk("R8 lines released", {sdaOe, sclOe}, 2'b00);
    arbOn = 1'b0;
    extSdaLow = 1'b0;
    waitCycles(5);
    regWrite(2'd1, 8'h28);
    waitCycles(10);
    chk("R8 stays idle", {sdaOe, sclOe, irq}, 3'b000);
  endtask

  task automatic testBusy();
    extSdaLow = 1'b1;
    waitCycles(5);
    regWrite(2'd0, 8'h20);
    waitCycles(100);
    chk("R3 waits on busy bus", {sdaOe, sclOe, irq}, 3'b000);
    extSdaLow = 1'b0;
    waitIrq("R3 start after free");
    chk("R3 start status", statusCode, 8'h08);
    regWrite(2'd1, 8'h20);
    regWrite(2'd0, 8'h10);
    regWrite(2'd1, 8'h08);
    waitStop("R9 stop after busy");
  endtask

  task automatic testDisable();
    regWrite(2'd0, 8'h20);
    waitIrq("R4 start flag");
    regWrite(2'd1, 8'h60);
    waitCycles(4);
    chk("R10 lines released", {sdaOe, sclOe}, 2'b00);
    chk("R10 status idle", statusCode, 8'hF8);
    regWrite(2'd1, 8'h08);
    regWrite(2'd0, 8'h40);
    waitCycles(20);
    chk("R10 no restart", {sdaOe, sclOe}, 2'b00);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);
    testReset();
    testRegs();
    regWrite(2'd0, 8'h40);
    testWrite();
    testAddrNack();
    testArb();
    testBusy();
    testDisable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule